// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered record of every destination-register rename made by the rename stage for one thread. Each record holds the instruction's sequence number, the architectural register it wrote, the physical register it was just given, and the physical register that held that architectural register before. The rename map and the free list sit outside the block. The block tells them what to undo and what to release.

Two walks empty the record. A squash names the youngest surviving sequence number. The block then removes records from the young end, one per cycle. For each one it writes the old physical register back into the map and returns the new physical register to the free list. A full flush does the same for every record, which puts the map back in its committed state. A commit names the youngest committed sequence number. The block then removes records from the old end, one per cycle, and returns each record's previous physical register to the free list. The control is a three-state machine: `HB_IDLE`, `HB_UNDO` (squash walk) and `HB_RETIRE` (commit walk).

Transitions:
- `HB_IDLE`/`HB_RETIRE` to `HB_UNDO` when a squash arrives and the buffer is not empty.
- `HB_IDLE` to `HB_RETIRE` when a commit arrives, no squash is present, and the oldest record qualifies.
- `HB_UNDO` to `HB_IDLE` once the youngest record survives or the buffer is empty.
- `HB_RETIRE` to `HB_IDLE` once the oldest record is younger than the target or the buffer is empty.
- A squash arriving during any state reloads the target and enters or stays in `HB_UNDO`.

Top module: `rename_history`

## Requirements
- R1: A push is accepted in a cycle where `push_valid` and `push_ready` are both high. `push_ready` is low whenever DEPTH records are held.
- R2: During a squash walk, one record is removed per cycle, youngest first. Each removal raises `map_we` with `map_areg`/`map_preg` set to that record's architectural and previous physical register. In the same cycle it raises `free_en` with `free_preg` set to the record's new physical register.
- R3: A squash walk removes exactly the records whose sequence number is strictly greater than `squash_seq` (unsigned compare). Records at or below it stay held.
- R4: A squash with `squash_all` high removes every held record in the R2 manner.
- R5: A commit walk removes records oldest first, one per cycle, while the sequence number is at or below `commit_seq`. Each removal raises `free_en` with the previous physical register and keeps `map_we` low.
- R6: A commit that arrives while the buffer is empty, or while the oldest record's sequence number is above `commit_seq`, frees nothing and leaves `busy` low.
- R7: A commit is dropped in a cycle where `squash_valid` is high, and also while a squash walk is running. No retirement happens in the cycle a squash is signalled.
- R8: A squash while the buffer is empty produces no map write and no free, and leaves `busy` low.
- R9: The first removal of a walk appears in the cycle after the request. `busy` is high for the whole walk. `push_ready` is low while a squash walk is running.
- R10: After reset the buffer is empty, `busy` is low, `push_ready` is high, and `map_we` and `free_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Rename offers a record |
| push_seq | input | SEQ_W | Sequence number of the renaming instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_new | input | PREG_W | Newly assigned physical register |
| push_prev | input | PREG_W | Physical register previously mapped |
| push_ready | output | 1 | Record can be accepted |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| squash_all | input | 1 | Squash removes every record |
| map_we | output | 1 | Restore write to the rename map |
| map_areg | output | AREG_W | Architectural register to restore |
| map_preg | output | PREG_W | Physical register restored into the map |
| free_en | output | 1 | Return a physical register to the free list |
| free_preg | output | PREG_W | Physical register returned |
| busy | output | 1 | A squash or commit walk is in progress |

## Verification
The bench fills the buffer with eight records whose sequence numbers are 1, 4, ..., 22. It sweeps the squash number over 0..25, which tells apart an over-undo, an under-undo and a wrong ordering at every boundary. For each point it then drains the survivors with a commit, which shows they were kept intact. A matching sweep of the commit number separates the "at or below" bound from the strict one, and a flush then undoes the remainder. Requests on an empty buffer, a commit raised together with a squash, and a commit raised inside a running squash walk show whether ignored commits leak into the later drain.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        HB_IDLE   = 2'd0,
        HB_UNDO   = 2'd1,
        HB_RETIRE = 2'd2
    } hb_state_e;
endpackage

// File: rtl/hb_store.sv
// Circular record storage: push at the young end, pop at either end.
module hb_store #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 8,
    parameter int AREG_W = 5,
    parameter int PREG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [AREG_W-1:0] in_areg,
    input  logic [PREG_W-1:0] in_new,
    input  logic [PREG_W-1:0] in_prev,
    input  logic              pop_old,
    input  logic              pop_young,
    output logic [SEQ_W-1:0]  old_seq,
    output logic [PREG_W-1:0] old_prev,
    output logic [SEQ_W-1:0]  yng_seq,
    output logic [AREG_W-1:0] yng_areg,
    output logic [PREG_W-1:0] yng_new,
    output logic [PREG_W-1:0] yng_prev,
    output logic              empty,
    output logic              full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    logic [SEQ_W-1:0]  seq_q  [DEPTH];
    logic [AREG_W-1:0] areg_q [DEPTH];
    logic [PREG_W-1:0] new_q  [DEPTH];
    logic [PREG_W-1:0] prev_q [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q, yidx;
    logic [CNT_W-1:0]  cnt_q;

    assign yidx  = (tail_q == '0) ? LAST : tail_q - 1'b1;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign count = cnt_q;

    assign old_seq  = seq_q[head_q];
    assign old_prev = prev_q[head_q];
    assign yng_seq  = seq_q[yidx];
    assign yng_areg = areg_q[yidx];
    assign yng_new  = new_q[yidx];
    assign yng_prev = prev_q[yidx];

    always_ff @(posedge clk) begin
        if (push_en) begin
            seq_q[tail_q]  <= in_seq;
            areg_q[tail_q] <= in_areg;
            new_q[tail_q]  <= in_new;
            prev_q[tail_q] <= in_prev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_en)
                tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
            else if (pop_young)
                tail_q <= yidx;
            if (pop_old)
                head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(push_en) - CNT_W'(pop_old) - CNT_W'(pop_young);
        end
    end
endmodule

// File: rtl/hb_ctrl.sv
// Walk controller: squash walk (young end) and commit walk (old end).
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sq_req,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             sq_all,
    input  logic             cm_req,
    input  logic [SEQ_W-1:0] cm_seq,
    input  logic             empty,
    input  logic [SEQ_W-1:0] old_seq,
    input  logic [SEQ_W-1:0] yng_seq,
    output logic             undo_fire,
    output logic             retire_fire,
    output logic             walking,
    output logic             undo_walk
);
    hb_state_e        state_q, state_d;
    logic [SEQ_W-1:0] tgt_q, tgt_d;
    logic             all_q, all_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HB_IDLE;
            tgt_q   <= '0;
            all_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            all_q   <= all_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        all_d   = all_q;
        if (sq_req) begin
            tgt_d   = sq_seq;
            all_d   = sq_all;
            state_d = empty ? HB_IDLE : HB_UNDO;
        end else begin
            unique case (state_q)
                HB_IDLE: begin
                    if (cm_req && !empty && (old_seq <= cm_seq)) begin
                        tgt_d   = cm_seq;
                        state_d = HB_RETIRE;
                    end
                end
                HB_UNDO: begin
                    if (!undo_fire) state_d = HB_IDLE;
                end
                HB_RETIRE: begin
                    if (cm_req) tgt_d = cm_seq;
                    else if (!retire_fire) state_d = HB_IDLE;
                end
                default: state_d = HB_IDLE;
            endcase
        end
    end

    always_comb begin
        undo_fire   = 1'b0;
        retire_fire = 1'b0;
        unique case (state_q)
            HB_UNDO:   undo_fire   = !sq_req && !empty && (all_q || (yng_seq > tgt_q));
            HB_RETIRE: retire_fire = !sq_req && !empty && (old_seq <= tgt_q);
            default: ;
        endcase
        walking   = (state_q != HB_IDLE);
        undo_walk = (state_q == HB_UNDO);
    end
endmodule

// File: rtl/rename_history.sv
module rename_history #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 8,
    parameter int AREG_W = 5,
    parameter int PREG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_new,
    input  logic [PREG_W-1:0] push_prev,
    output logic              push_ready,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              squash_all,
    output logic              map_we,
    output logic [AREG_W-1:0] map_areg,
    output logic [PREG_W-1:0] map_preg,
    output logic              free_en,
    output logic [PREG_W-1:0] free_preg,
    output logic              busy
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [SEQ_W-1:0]  old_seq, yng_seq;
    logic [AREG_W-1:0] yng_areg;
    logic [PREG_W-1:0] old_prev, yng_new, yng_prev;
    logic              empty, full, undo_fire, retire_fire, walking, undo_walk;
    logic [CNT_W-1:0]  count;
    logic              push_en;

    assign push_ready = !full && !undo_walk && !squash_valid;
    assign push_en    = push_valid && push_ready;

    hb_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push_en(push_en),
        .in_seq(push_seq), .in_areg(push_areg), .in_new(push_new), .in_prev(push_prev),
        .pop_old(retire_fire), .pop_young(undo_fire),
        .old_seq(old_seq), .old_prev(old_prev),
        .yng_seq(yng_seq), .yng_areg(yng_areg), .yng_new(yng_new), .yng_prev(yng_prev),
        .empty(empty), .full(full), .count(count)
    );

    hb_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sq_req(squash_valid), .sq_seq(squash_seq), .sq_all(squash_all),
        .cm_req(commit_valid), .cm_seq(commit_seq),
        .empty(empty), .old_seq(old_seq), .yng_seq(yng_seq),
        .undo_fire(undo_fire), .retire_fire(retire_fire),
        .walking(walking), .undo_walk(undo_walk)
    );

    always_comb begin
        map_we    = undo_fire;
        map_areg  = yng_areg;
        map_preg  = yng_prev;
        free_en   = undo_fire || retire_fire;
        free_preg = undo_fire ? yng_new : old_prev;
        busy      = walking;
    end
endmodule

// File: rtl/rename_history_checker.sv
module rename_history_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             push_ready,
    input logic             squash_valid,
    input logic             map_we,
    input logic             free_en,
    input logic             busy,
    input logic [CNT_W-1:0] count
);
    assert_full_blocks_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH)) |-> !push_ready);
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_restore_pairs_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> (free_en && busy));
    assert_undo_blocks_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> !push_ready);
    assert_no_retire_on_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !free_en);
    assert_idle_is_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !free_en);
    assert_idle_count_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(push_valid && push_ready)) |=> (count == $past(count)));
endmodule

bind rename_history rename_history_checker #(.DEPTH(DEPTH), .CNT_W($clog2(DEPTH+1))) u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .squash_valid(squash_valid), .map_we(map_we), .free_en(free_en), .busy(busy),
    .count(count)
);

// File: tb/rename_history_test.sv
`timescale 1ns/100ps
module rename_history_test;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_seq = '0;
    logic [4:0] push_areg = '0;
    logic [5:0] push_new = '0, push_prev = '0;
    logic       push_ready;
    logic       commit_valid = 1'b0;
    logic [7:0] commit_seq = '0;
    logic       squash_valid = 1'b0;
    logic [7:0] squash_seq = '0;
    logic       squash_all = 1'b0;
    logic       map_we, free_en, busy;
    logic [4:0] map_areg;
    logic [5:0] map_preg, free_preg;

    int checks = 0, errors = 0;
    int got_n, first_t;
    int got_free [16];
    int got_we   [16];
    int got_areg [16];
    int got_mp   [16];
    int exp_idx  [16];
    int exp_n;

    always #2.5 clk = ~clk;

    rename_history uut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_seq(push_seq), .push_areg(push_areg),
        .push_new(push_new), .push_prev(push_prev), .push_ready(push_ready),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq), .squash_all(squash_all),
        .map_we(map_we), .map_areg(map_areg), .map_preg(map_preg),
        .free_en(free_en), .free_preg(free_preg), .busy(busy)
    );

    function automatic int e_seq(int i);  return 3*i + 1; endfunction
    function automatic int e_areg(int i); return i + 2;   endfunction
    function automatic int e_new(int i);  return 40 + i;  endfunction
    function automatic int e_prev(int i); return 20 + i;  endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_all();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            push_valid = 1'b1;
            push_seq   = 8'(e_seq(i));
            push_areg  = 5'(e_areg(i));
            push_new   = 6'(e_new(i));
            push_prev  = 6'(e_prev(i));
            #1;
            check(push_ready == 1'b1, "R1 ready while not full", int'(push_ready), 1);
        end
        @(negedge clk);
        push_valid = 1'b0;
        #1;
        check(push_ready == 1'b0, "R1 ready low when full", int'(push_ready), 0);
    endtask

    // Issue one request cycle, then record every removal until the walk ends.
    task automatic walk(input bit sq, input bit all, input int sseq,
                        input bit cm, input int cseq, input bit inject);
        @(negedge clk);
        squash_valid = sq; squash_all = all; squash_seq = 8'(sseq);
        commit_valid = cm; commit_seq = 8'(cseq);
        @(negedge clk);
        squash_valid = 1'b0; squash_all = 1'b0; commit_valid = 1'b0;
        #1;
        got_n = 0; first_t = -1;
        for (int t = 0; t < 40; t++) begin
            if (free_en) begin
                if (first_t < 0) first_t = t;
                got_free[got_n] = int'(free_preg);
                got_we[got_n]   = int'(map_we);
                got_areg[got_n] = int'(map_areg);
                got_mp[got_n]   = int'(map_preg);
                if (map_we)
                    check(push_ready == 1'b0, "R9 push blocked in undo walk", int'(push_ready), 0);
                got_n++;
            end
            if (inject && t == 1) begin commit_valid = 1'b1; commit_seq = 8'd255; end
            if (inject && t == 2) commit_valid = 1'b0;
            if (!busy) break;
            @(negedge clk);
            #1;
        end
        commit_valid = 1'b0;
    endtask

    // Compare recorded removals with exp_idx; undo=1 means squash-style.
    task automatic compare(input string req, input bit undo);
        check(got_n == exp_n, req, got_n, exp_n);
        if (exp_n > 0)
            check(first_t == 0, "R9 first removal one cycle after request", first_t, 0);
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            int i = exp_idx[k];
            if (undo) begin
                check(got_free[k] == e_new(i), req, got_free[k], e_new(i));
                check(got_we[k] == 1, "R2 map write with undo", got_we[k], 1);
                check(got_areg[k] == e_areg(i), "R2 restore areg", got_areg[k], e_areg(i));
                check(got_mp[k] == e_prev(i), "R2 restore preg", got_mp[k], e_prev(i));
            end else begin
                check(got_free[k] == e_prev(i), req, got_free[k], e_prev(i));
                check(got_we[k] == 0, "R5 no map write on retire", got_we[k], 0);
            end
        end
    endtask

    task automatic exp_young_above(input int s);
        exp_n = 0;
        for (int i = N-1; i >= 0; i--) if (e_seq(i) > s) begin exp_idx[exp_n] = i; exp_n++; end
    endtask

    task automatic exp_old_upto(input int c, input int lo);
        exp_n = 0;
        for (int i = 0; i < N; i++)
            if (e_seq(i) <= c && e_seq(i) > lo) begin exp_idx[exp_n] = i; exp_n++; end
    endtask

    task automatic exp_young_range(input int lo, input int hi);
        exp_n = 0;
        for (int i = N-1; i >= 0; i--)
            if (e_seq(i) > lo && e_seq(i) <= hi) begin exp_idx[exp_n] = i; exp_n++; end
    endtask

    initial begin : watchdog
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
        check(push_ready == 1'b1, "R10 ready after reset", int'(push_ready), 1);
        check(free_en == 1'b0, "R10 no free after reset", int'(free_en), 0);
        check(map_we == 1'b0, "R10 no map write after reset", int'(map_we), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8, R6: requests on an empty buffer
        walk(1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
        exp_n = 0; compare("R8 squash on empty", 1'b1);
        check(busy == 1'b0, "R8 stays idle", int'(busy), 0);
        walk(1'b0, 1'b0, 0, 1'b1, 255, 1'b0);
        exp_n = 0; compare("R6 commit on empty", 1'b0);

        // R2, R3: squash sweep, survivors drained by commit
        for (int s = 0; s <= 25; s++) begin
            push_all();
            walk(1'b1, 1'b0, s, 1'b0, 0, 1'b0);
            exp_young_above(s); compare("R3 squash sweep undo list", 1'b1);
            walk(1'b0, 1'b0, 0, 1'b1, 255, 1'b0);
            exp_old_upto(s, -1); compare("R3 survivors kept", 1'b0);
        end

        // R5, R6, R4: commit sweep, remainder flushed
        for (int c = 0; c <= 25; c++) begin
            push_all();
            walk(1'b0, 1'b0, 0, 1'b1, c, 1'b0);
            exp_old_upto(c, -1); compare("R5 R6 commit sweep retire list", 1'b0);
            walk(1'b1, 1'b1, 0, 1'b0, 0, 1'b0);
            exp_young_above(c); compare("R4 flush undoes all remaining", 1'b1);
        end

        // R7: commit raised with a squash is dropped
        push_all();
        walk(1'b1, 1'b0, 10, 1'b1, 255, 1'b0);
        exp_young_above(10); compare("R7 squash wins same cycle", 1'b1);
        walk(1'b0, 1'b0, 0, 1'b1, 255, 1'b0);
        exp_old_upto(10, -1); compare("R7 dropped commit left survivors", 1'b0);

        // R7: commit raised inside a squash walk is dropped
        push_all();
        walk(1'b1, 1'b0, 13, 1'b0, 0, 1'b1);
        exp_young_above(13); compare("R7 undo list with commit inside walk", 1'b1);
        walk(1'b0, 1'b0, 0, 1'b1, 4, 1'b0);
        exp_old_upto(4, -1); compare("R7 commit after walk retires only up to 4", 1'b0);
        walk(1'b1, 1'b1, 0, 1'b0, 0, 1'b0);
        exp_young_range(4, 13); compare("R4 flush of the rest", 1'b1);

        check(busy == 1'b0, "R9 idle at end", int'(busy), 0);
        check(push_ready == 1'b1, "R1 ready when empty", int'(push_ready), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule